// File: doc/BRIEF.md
# Boot-Stage Isolation Level Gate

This block tracks how far the boot chain has progressed and decides, for each flash access, whether that access may go ahead. It holds a four-step isolation level, from 0 to 3. A one-cycle strobe moves the level up, and only a reset moves it back down. Each flash bank has a base protected window, given as an inclusive first and last sector. The windows are captured from configuration inputs while reset is held. Once the boot code has moved past level 1, every sector in a bank's base window is hidden. A volatile extension count can also be written. It names how many sectors directly after each base window are hidden once the final level is reached. That count can only grow, and it freezes at the final level.

The accessor presents a bank index and a sector on each access, or marks the access as a key-storage access. One cycle later the block answers with a grant pulse or a violation pulse, and a denied access goes no further. The current level and the extension count are visible as outputs.

Top module: `iso_gate`

## Requirements
- R1: While `rst` is high, the level and the extension count clear to 0, both response pulses stay low, and each bank's window bounds are taken from `cfg_lo_i`/`cfg_hi_i`. Bank b uses bits [b*SEC_W +: SEC_W].
- R2: A cycle with `lvl_up_i` high raises `level_o` by exactly one at the next clock edge, and the level stays at 3 once it gets there. Nothing but reset lowers the level.
- R3: Every cycle with `acc_valid_i` high gives exactly one of `acc_grant_o` or `acc_viol_o`, high for one cycle and registered one cycle later. Both stay low after a cycle without `acc_valid_i`. The decision uses the level held before any strobe in the same cycle.
- R4: A sector inside the selected bank's inclusive window [lo, hi] is granted at levels 0 and 1 and denied at levels 2 and 3. Sectors outside the window are not affected by this rule.
- R5: A bank whose `hi` is below its `lo` has no base window and no extension. All of its sectors are granted at every level.
- R6: With extension count T > 0, sectors hi+1 through hi+T of a bank are denied at level 3 and granted at lower levels. Sector hi+T+1 is granted. With T = 0 there is no extension.
- R7: A `thr_wr_i` write below level 3 updates `thr_o` only if `thr_data_i` is at least the current count. A lower value leaves the count unchanged.
- R8: At level 3, `thr_wr_i` writes never change `thr_o`.
- R9: An access with `acc_key_i` high targets key storage, and its bank and sector are ignored. It is granted at levels up to `KEY_OPEN_MAX` (default 2) and denied above it.
- R10: Each bank is checked only against its own window. The same sector can be denied in one bank and granted in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the window bounds |
| cfg_lo_i | input | NUM_BANKS*SEC_W | First sector of each bank's base window |
| cfg_hi_i | input | NUM_BANKS*SEC_W | Last sector of each bank's base window |
| lvl_up_i | input | 1 | Level raise strobe |
| thr_wr_i | input | 1 | Extension count write enable |
| thr_data_i | input | SEC_W | Extension count write value |
| acc_valid_i | input | 1 | Access request |
| acc_key_i | input | 1 | Access targets key storage |
| acc_bank_i | input | BANK_W | Bank index of the access |
| acc_sector_i | input | SEC_W | Sector index of the access |
| acc_grant_o | output | 1 | Access allowed (one-cycle pulse) |
| acc_viol_o | output | 1 | Access denied (one-cycle pulse) |
| level_o | output | 2 | Current isolation level |
| thr_o | output | SEC_W | Current extension count |

## Verification
The access decision is tried at each level on sectors placed at the window edges, where lo-1, lo, hi and hi+1 separate an off-by-one on either bound. It is also tried at the last extended sector and the sector just after it, which separate the extension length from its start. A bank with an empty window and a bank with a real window are probed at the same sector to show that each bank keeps its own bounds, and key-storage accesses are tried across the level boundary. Lower, equal and frozen-level writes to the extension count show the monotonic and freeze rules. An access issued together with a level strobe shows which level the decision sees.

// File: rtl/iso_pkg.sv
package iso_pkg;

    typedef enum logic [1:0] {
        LVL_BOOT  = 2'd0,
        LVL_ROOT  = 2'd1,
        LVL_STAGE = 2'd2,
        LVL_APP   = 2'd3
    } iso_lvl_e;

    // widened arithmetic so hi + count never wraps (sector width up to 16)
    localparam int SPAN_W = 17;

    typedef struct packed {
        logic grant;
        logic viol;
    } iso_resp_t;

    typedef struct packed {
        logic in_base;
        logic in_ext;
    } iso_hit_t;

    function automatic logic span_has(input logic [SPAN_W-1:0] pos,
                                      input logic [SPAN_W-1:0] lo,
                                      input logic [SPAN_W-1:0] hi);
        return (pos >= lo) && (pos <= hi);
    endfunction

    function automatic iso_lvl_e lvl_next(input iso_lvl_e cur);
        return (cur == LVL_APP) ? LVL_APP : iso_lvl_e'(cur + 2'd1);
    endfunction

endpackage

// File: rtl/iso_level_ctr.sv
module iso_level_ctr
    import iso_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     step_i,
    output iso_lvl_e lvl_o
);

    always_ff @(posedge clk) begin
        if (rst)
            lvl_o <= LVL_BOOT;
        else if (step_i)
            lvl_o <= lvl_next(lvl_o);
    end

endmodule

// File: rtl/iso_thr_reg.sv
module iso_thr_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frozen_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] thr_o
);

    logic take;

    // ignore writes that would shrink the count or arrive after freezing
    assign take = wr_i && !frozen_i && (wdata_i >= thr_o);

    always_ff @(posedge clk) begin
        if (rst)
            thr_o <= '0;
        else if (take)
            thr_o <= wdata_i;
    end

endmodule

// File: rtl/iso_bank_region.sv
module iso_bank_region
    import iso_pkg::*;
#(
    parameter int SEC_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEC_W-1:0] cfg_lo_i,
    input  logic [SEC_W-1:0] cfg_hi_i,
    input  logic [SEC_W-1:0] thr_i,
    input  logic [SEC_W-1:0] sector_i,
    output iso_hit_t         hit_o
);

    logic [SEC_W-1:0]  lo_q, hi_q;
    logic [SPAN_W-1:0] lo_x, hi_x, sec_x, thr_x;
    logic              win_ok;

    // bounds are latched only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= cfg_lo_i;
            hi_q <= cfg_hi_i;
        end
    end

    always_comb begin
        lo_x   = SPAN_W'(lo_q);
        hi_x   = SPAN_W'(hi_q);
        sec_x  = SPAN_W'(sector_i);
        thr_x  = SPAN_W'(thr_i);
        win_ok = (hi_q >= lo_q);
        hit_o.in_base = win_ok && span_has(sec_x, lo_x, hi_x);
        hit_o.in_ext  = win_ok && (thr_i != '0)
                        && span_has(sec_x, hi_x + SPAN_W'(1), hi_x + thr_x);
    end

endmodule

// File: rtl/iso_gate.sv
module iso_gate
    import iso_pkg::*;
#(
    parameter int NUM_BANKS    = 2,
    parameter int SECTORS      = 128,
    parameter int KEY_OPEN_MAX = 2,
    localparam int SEC_W  = $clog2(SECTORS),
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_BANKS*SEC_W-1:0] cfg_lo_i,
    input  logic [NUM_BANKS*SEC_W-1:0] cfg_hi_i,
    input  logic                       lvl_up_i,
    input  logic                       thr_wr_i,
    input  logic [SEC_W-1:0]           thr_data_i,
    input  logic                       acc_valid_i,
    input  logic                       acc_key_i,
    input  logic [BANK_W-1:0]          acc_bank_i,
    input  logic [SEC_W-1:0]           acc_sector_i,
    output logic                       acc_grant_o,
    output logic                       acc_viol_o,
    output logic [1:0]                 level_o,
    output logic [SEC_W-1:0]           thr_o
);

    iso_lvl_e  lvl;
    iso_hit_t  hits [NUM_BANKS];
    iso_hit_t  sel;
    logic      bank_ok;
    logic      deny;
    iso_resp_t resp_q;

    iso_level_ctr u_lvl (
        .clk    (clk),
        .rst    (rst),
        .step_i (lvl_up_i),
        .lvl_o  (lvl)
    );

    iso_thr_reg #(.W(SEC_W)) u_thr (
        .clk      (clk),
        .rst      (rst),
        .frozen_i (lvl == LVL_APP),
        .wr_i     (thr_wr_i),
        .wdata_i  (thr_data_i),
        .thr_o    (thr_o)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        iso_bank_region #(.SEC_W(SEC_W)) u_region (
            .clk      (clk),
            .rst      (rst),
            .cfg_lo_i (cfg_lo_i[b*SEC_W +: SEC_W]),
            .cfg_hi_i (cfg_hi_i[b*SEC_W +: SEC_W]),
            .thr_i    (thr_o),
            .sector_i (acc_sector_i),
            .hit_o    (hits[b])
        );
    end

    always_comb begin
        sel     = '0;
        bank_ok = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (acc_bank_i == BANK_W'(b)) begin
                sel     = hits[b];
                bank_ok = 1'b1;
            end
        end
        if (acc_key_i)
            deny = (int'(lvl) > KEY_OPEN_MAX);
        else
            deny = !bank_ok
                   || ((lvl >= LVL_STAGE) && sel.in_base)
                   || ((lvl == LVL_APP) && sel.in_ext);
    end

    always_ff @(posedge clk) begin
        if (rst)
            resp_q <= '0;
        else begin
            resp_q.grant <= acc_valid_i && !deny;
            resp_q.viol  <= acc_valid_i && deny;
        end
    end

    assign acc_grant_o = resp_q.grant;
    assign acc_viol_o  = resp_q.viol;
    assign level_o     = lvl;

endmodule

// File: rtl/iso_gate_chk.sv
module iso_gate_chk #(
    parameter int NUM_BANKS    = 2,
    parameter int SECTORS      = 128,
    parameter int KEY_OPEN_MAX = 2,
    localparam int SEC_W  = $clog2(SECTORS),
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_BANKS*SEC_W-1:0] cfg_lo_i,
    input logic [NUM_BANKS*SEC_W-1:0] cfg_hi_i,
    input logic                       lvl_up_i,
    input logic                       thr_wr_i,
    input logic [SEC_W-1:0]           thr_data_i,
    input logic                       acc_valid_i,
    input logic                       acc_key_i,
    input logic [BANK_W-1:0]          acc_bank_i,
    input logic [SEC_W-1:0]           acc_sector_i,
    input logic                       acc_grant_o,
    input logic                       acc_viol_o,
    input logic [1:0]                 level_o,
    input logic [SEC_W-1:0]           thr_o
);

    a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
        lvl_up_i && (level_o != 2'd3) |=> level_o == $past(level_o) + 2'd1);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !lvl_up_i |=> $stable(level_o));

    a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
        (level_o == 2'd3) |=> (level_o == 2'd3));

    a_r7_no_write_hold: assert property (@(posedge clk) disable iff (rst)
        !thr_wr_i |=> $stable(thr_o));

    a_r7_lower_ignored: assert property (@(posedge clk) disable iff (rst)
        thr_wr_i && (thr_data_i < thr_o) |=> $stable(thr_o));

    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (level_o == 2'd3) |=> $stable(thr_o));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !acc_valid_i |=> !acc_grant_o && !acc_viol_o);

    a_r3_one_answer: assert property (@(posedge clk) disable iff (rst)
        acc_valid_i |=> (acc_grant_o != acc_viol_o));

    a_r9_key_locked: assert property (@(posedge clk) disable iff (rst)
        acc_valid_i && acc_key_i && (int'(level_o) > KEY_OPEN_MAX) |=> acc_viol_o);

endmodule

bind iso_gate iso_gate_chk #(
    .NUM_BANKS    (NUM_BANKS),
    .SECTORS      (SECTORS),
    .KEY_OPEN_MAX (KEY_OPEN_MAX)
) u_iso_gate_chk (.*);

// File: tb/test_iso_gate.sv
module test_iso_gate;

    localparam int NB = 2;
    localparam int SW = 7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NB*SW-1:0] cfg_lo, cfg_hi;
    logic            lvl_up = 1'b0, thr_wr = 1'b0;
    logic [SW-1:0]   thr_data = '0;
    logic            acc_valid = 1'b0, acc_key = 1'b0;
    logic            acc_bank = 1'b0;
    logic [SW-1:0]   acc_sector = '0;
    logic            grant, viol;
    logic [1:0]      level;
    logic [SW-1:0]   thr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    iso_gate #(.NUM_BANKS(NB), .SECTORS(128), .KEY_OPEN_MAX(2)) i_iso_gate (
        .clk(clk), .rst(rst), .cfg_lo_i(cfg_lo), .cfg_hi_i(cfg_hi),
        .lvl_up_i(lvl_up), .thr_wr_i(thr_wr), .thr_data_i(thr_data),
        .acc_valid_i(acc_valid), .acc_key_i(acc_key), .acc_bank_i(acc_bank),
        .acc_sector_i(acc_sector), .acc_grant_o(grant), .acc_viol_o(viol),
        .level_o(level), .thr_o(thr)
    );

    typedef struct packed {
        logic [1:0]    lvl;
        logic          bank;
        logic [SW-1:0] sec;
        logic          key;
        logic          deny;
        logic [3:0]    req;
    } vec_t;

    // bank0 window 8..15, bank1 empty (hi 10 < lo 20), extension count 4
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 7'd8,  1'b0, 1'b0, 4'd4},   // R4
        '{2'd0, 1'b0, 7'd15, 1'b0, 1'b0, 4'd4},   // R4
        '{2'd0, 1'b0, 7'd0,  1'b1, 1'b0, 4'd9},   // R9
        '{2'd1, 1'b0, 7'd8,  1'b0, 1'b0, 4'd4},   // R4
        '{2'd1, 1'b0, 7'd17, 1'b0, 1'b0, 4'd6},   // R6
        '{2'd2, 1'b0, 7'd7,  1'b0, 1'b0, 4'd4},   // R4
        '{2'd2, 1'b0, 7'd8,  1'b0, 1'b1, 4'd4},   // R4
        '{2'd2, 1'b0, 7'd15, 1'b0, 1'b1, 4'd4},   // R4
        '{2'd2, 1'b0, 7'd16, 1'b0, 1'b0, 4'd6},   // R6
        '{2'd2, 1'b0, 7'd19, 1'b0, 1'b0, 4'd6},   // R6
        '{2'd2, 1'b1, 7'd15, 1'b0, 1'b0, 4'd10},  // R10
        '{2'd2, 1'b1, 7'd20, 1'b0, 1'b0, 4'd5},   // R5
        '{2'd2, 1'b0, 7'd3,  1'b1, 1'b0, 4'd9},   // R9
        '{2'd3, 1'b0, 7'd12, 1'b0, 1'b1, 4'd4},   // R4
        '{2'd3, 1'b0, 7'd16, 1'b0, 1'b1, 4'd6},   // R6
        '{2'd3, 1'b0, 7'd19, 1'b0, 1'b1, 4'd6},   // R6
        '{2'd3, 1'b0, 7'd20, 1'b0, 1'b0, 4'd6},   // R6
        '{2'd3, 1'b1, 7'd16, 1'b0, 1'b0, 4'd5},   // R5
        '{2'd3, 1'b1, 7'd10, 1'b0, 1'b0, 4'd5},   // R5
        '{2'd3, 1'b0, 7'd0,  1'b1, 1'b1, 4'd9},   // R9
        '{2'd3, 1'b0, 7'd0,  1'b0, 1'b0, 4'd4},   // R4
        '{2'd3, 1'b1, 7'd8,  1'b0, 1'b0, 4'd10}   // R10
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic raise();
        @(negedge clk); lvl_up = 1'b1;
        @(negedge clk); lvl_up = 1'b0;
    endtask

    task automatic write_thr(input logic [SW-1:0] v);
        @(negedge clk); thr_wr = 1'b1; thr_data = v;
        @(negedge clk); thr_wr = 1'b0;
    endtask

    // drive one access; response is registered and read one cycle later
    task automatic access(input logic bank, input logic [SW-1:0] sec, input logic key,
                          input logic with_up, output logic g, output logic v);
        @(negedge clk);
        acc_valid = 1'b1; acc_bank = bank; acc_sector = sec; acc_key = key; lvl_up = with_up;
        @(negedge clk);
        acc_valid = 1'b0; lvl_up = 1'b0;
        g = grant; v = viol;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic g, v;
        cfg_lo = {7'd20, 7'd8};
        cfg_hi = {7'd10, 7'd15};
        do_reset();

        // R1 reset state
        check(level, 0, "R1 level after reset");
        check(thr,   0, "R1 count after reset");
        check(grant, 0, "R1 grant after reset");
        check(viol,  0, "R1 viol after reset");

        // R3 idle cycle gives no response
        @(negedge clk);
        check({grant, viol}, 0, "R3 idle quiet");

        // R7 count grows, lower write ignored
        write_thr(7'd4);
        check(thr, 4, "R7 raise count");
        write_thr(7'd2);
        check(thr, 4, "R7 lower write ignored");

        for (int i = 0; i < NV; i++) begin
            while (level < VECS[i].lvl) raise();
            access(VECS[i].bank, VECS[i].sec, VECS[i].key, 1'b0, g, v);
            checks++;
            if ({g, v} !== {~VECS[i].deny, VECS[i].deny}) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual grant=%0b viol=%0b expected viol=%0b",
                         VECS[i].req, i, g, v, VECS[i].deny);
            end
        end

        // R8 frozen count at level 3
        write_thr(7'd9);
        check(thr, 4, "R8 write at final level ignored");
        // R2 saturation
        raise();
        check(level, 3, "R2 saturate at 3");

        // R1 reset lowers everything again
        do_reset();
        check(level, 0, "R1 level cleared by reset");
        check(thr,   0, "R1 count cleared by reset");

        // R2 single step
        raise();
        check(level, 1, "R2 step by one");

        // R3 access with simultaneous strobe sees old level (1): granted
        access(1'b0, 7'd8, 1'b0, 1'b1, g, v);
        check({g, v}, 2'b10, "R3 decision uses pre-strobe level");
        check(level, 2, "R2 step during access");
        access(1'b0, 7'd8, 1'b0, 1'b0, g, v);
        check({g, v}, 2'b01, "R4 base window hidden at level 2");

        // R6 zero count: no extension at level 3
        raise();
        access(1'b0, 7'd16, 1'b0, 1'b0, g, v);
        check({g, v}, 2'b10, "R6 zero count no extension");
        access(1'b0, 7'd15, 1'b0, 1'b0, g, v);
        check({g, v}, 2'b01, "R4 last window sector at level 3");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule